// File: doc/BRIEF.md
# Programmable Weak-Write Pulse Timer

This block times the write pulse of one bit line of a resistive memory array. In functional operation every write holds the write-pulse enable high for a fixed nominal number of clock cycles. With the test-mode input high, the same write is cut short. The length then comes from a table of stress durations, and a select code picks the entry. The write voltage is not touched by this block. Only the time the enable stays high changes. A cell that already sits between its two logic levels is pushed into a wrong state by this short write, and a healthy cell is left alone.

The durations are cycle counts held in a parameter vector. They are filled in from characterisation data. The number of settings is a power of two. The select code is decoded into a one-hot select that drives a single down-counter. The counter is shared between the nominal and the stress paths, and one instance serves each bit line. A trigger is accepted only while no pulse is running. The mode and the code are captured at that moment, and a one-cycle done strobe marks the end of each pulse.

Top module: `weak_write_timer`

## Requirements
- R1: After reset, and with no trigger applied, both wrPulseEn and wrDone are low.
- R2: When dftEn is low at an accepted trigger, wrPulseEn goes high in the cycle after the trigger edge and stays high for exactly NOM_CYCLES cycles (40 by default).
- R3: When dftEn is high at an accepted trigger, wrPulseEn stays high for exactly the stress count that stressSel selects. In the default table, code k (an unsigned value, 0 to 15) gives 2k+2 cycles.
- R4: Select code 0 gives the first table entry, which is the shortest duration (2 cycles by default). Code 15 gives the last entry (32 cycles).
- R5: dftEn and stressSel are captured at the accepted trigger. Changing them while the pulse runs changes neither its length nor its mode.
- R6: wrDone is high for exactly one cycle: the first cycle in which wrPulseEn is low again after a pulse. It is low in every other cycle.
- R7: A wrTrig seen at any clock edge while wrPulseEn is high is ignored. It neither lengthens the pulse nor causes a second pulse.
- R8: A trigger applied in the cycle where wrDone is high is accepted, so pulses can run back to back with one low cycle between them.
- R9: The stress select drives the counter through a decoded select that is exactly one-hot whenever a trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dftEn | input | 1 | High selects a shortened stress write |
| stressSel | input | SEL_W (4) | Code that picks the stress duration |
| wrTrig | input | 1 | Write request, sampled on each rising edge |
| wrPulseEn | output | 1 | Write-pulse enable to the bit-line driver |
| wrDone | output | 1 | One-cycle strobe after the pulse ends |

## Verification
The assertions assume that wrTrig, dftEn and stressSel are known values at every rising edge after reset. They also assume that the parameter table holds counts between 1 and NOM_CYCLES-1, so the counter never starts from an out-of-range value. The stimulus changes inputs only on falling edges and draws every select code and mode from a fixed-seed generator. While pulses run, it deliberately toggles the trigger, the mode and the code. This exercises the capture and ignore rules without ever feeding an unknown value.

// File: rtl/wwt_pkg.sv
package wwt_pkg;
  typedef struct packed {
    logic load;
    logic useStress;
    logic step;
  } wwtStrobe_t;
endpackage

// File: rtl/wwt_ctrl.sv
module wwt_ctrl
  import wwt_pkg::*;
#(
  parameter int NUM_SEL = 16,
  localparam int SEL_W = $clog2(NUM_SEL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dftEn,
  input  logic [SEL_W-1:0]   stressSel,
  input  logic               wrTrig,
  input  logic               cntZero,
  output wwtStrobe_t         strobe,
  output logic [NUM_SEL-1:0] selOneHot,
  output logic               pulseActive,
  output logic               pulseDone
);

  logic accept;
  logic finish;

  // one-hot decode of the select code
  for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_dec
    assign selOneHot[gi] = (stressSel == SEL_W'(gi));
  end

  assign accept = !pulseActive && wrTrig;
  assign finish = pulseActive && cntZero;

  always_comb begin
    strobe.load      = accept;
    strobe.useStress = dftEn;
    strobe.step      = pulseActive && !cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseActive <= 1'b0;
      pulseDone   <= 1'b0;
    end else begin
      pulseDone <= finish;
      if (accept)      pulseActive <= 1'b1;
      else if (finish) pulseActive <= 1'b0;
    end
  end

  // R9
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> $onehot(selOneHot));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseDone |=> !pulseDone);

  // R6
  done_after_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseActive) |-> pulseDone);

  // R7
  trig_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive && !cntZero |=> pulseActive);

  // R1
  start_needs_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> $past(wrTrig));

endmodule

// File: rtl/wwt_datapath.sv
module wwt_datapath
  import wwt_pkg::*;
#(
  parameter int NUM_SEL    = 16,
  parameter int CNT_W      = 8,
  parameter int NOM_CYCLES = 40,
  parameter logic [NUM_SEL*CNT_W-1:0] STRESS_CYCLES = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  wwtStrobe_t         strobe,
  input  logic [NUM_SEL-1:0] selOneHot,
  output logic               cntZero
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] masked [NUM_SEL];
  logic [CNT_W-1:0] stressLen;
  logic [CNT_W-1:0] chosenLen;

  // AND-OR selection of the stress duration
  for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_mask
    assign masked[gi] = selOneHot[gi] ? STRESS_CYCLES[gi*CNT_W +: CNT_W] : '0;
  end

  always_comb begin
    stressLen = '0;
    for (int i = 0; i < NUM_SEL; i++) stressLen = stressLen | masked[i];
  end

  assign chosenLen = strobe.useStress ? stressLen : CNT_W'(NOM_CYCLES);
  assign cntZero   = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.load) count <= chosenLen - 1'b1;
    else if (strobe.step) count <= count - 1'b1;
  end

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    count < CNT_W'(NOM_CYCLES));

  // R5
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load && !strobe.step |=> $stable(count));

endmodule

// File: rtl/weak_write_timer.sv
module weak_write_timer
  import wwt_pkg::*;
#(
  parameter int NUM_SEL    = 16,
  parameter int CNT_W      = 8,
  parameter int NOM_CYCLES = 40,
  parameter logic [NUM_SEL*CNT_W-1:0] STRESS_CYCLES = {
    8'd32, 8'd30, 8'd28, 8'd26, 8'd24, 8'd22, 8'd20, 8'd18,
    8'd16, 8'd14, 8'd12, 8'd10, 8'd8,  8'd6,  8'd4,  8'd2 },
  localparam int SEL_W = $clog2(NUM_SEL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dftEn,
  input  logic [SEL_W-1:0] stressSel,
  input  logic             wrTrig,
  output logic             wrPulseEn,
  output logic             wrDone
);

  wwtStrobe_t         strobe;
  logic [NUM_SEL-1:0] selOneHot;
  logic               cntZero;

  wwt_ctrl #(.NUM_SEL(NUM_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .dftEn(dftEn), .stressSel(stressSel),
    .wrTrig(wrTrig), .cntZero(cntZero), .strobe(strobe),
    .selOneHot(selOneHot), .pulseActive(wrPulseEn), .pulseDone(wrDone));

  wwt_datapath #(
    .NUM_SEL(NUM_SEL), .CNT_W(CNT_W), .NOM_CYCLES(NOM_CYCLES),
    .STRESS_CYCLES(STRESS_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selOneHot(selOneHot),
    .cntZero(cntZero));

  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrDone && wrPulseEn));

endmodule

// File: tb/weak_write_timer_bench.sv
module weak_write_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dftEn = 1'b0;
  logic [3:0] stressSel = '0;
  logic wrTrig = 1'b0;
  logic wrPulseEn, wrDone;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  weak_write_timer u_weak_write_timer (
    .clk(clk), .rstN(rstN), .dftEn(dftEn), .stressSel(stressSel),
    .wrTrig(wrTrig), .wrPulseEn(wrPulseEn), .wrDone(wrDone));

  function automatic int expLen(input bit mode, input int sel);
    return mode ? 2 * sel + 2 : 40;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at a falling edge; trigger applied now. If noisy, inputs are
  // scrambled while the pulse runs (R5, R7). Returns at the done cycle.
  task automatic doPulse(input bit mode, input int sel, input bit noisy, input string req);
    int len = 0;
    dftEn = mode; stressSel = 4'(sel); wrTrig = 1'b1;
    @(negedge clk);
    wrTrig = 1'b0;
    while (wrPulseEn && len < 100) begin
      len++;
      if (noisy) begin
        wrTrig = 1'($urandom);
        dftEn = 1'($urandom);
        stressSel = 4'($urandom);
      end
      @(negedge clk);
    end
    wrTrig = 1'b0;
    check(len == expLen(mode, sel), req, len, expLen(mode, sel));
    check(wrDone == 1'b1, "R6 done after pulse", int'(wrDone), 1);
  endtask

  task automatic settle();
    @(negedge clk);
    check(wrDone == 1'b0, "R6 done one cycle", int'(wrDone), 0);
    check(wrPulseEn == 1'b0, "R7 no second pulse", int'(wrPulseEn), 0);
  endtask

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check(wrPulseEn == 1'b0, "R1 reset enable", int'(wrPulseEn), 0);
    check(wrDone == 1'b0, "R1 reset done", int'(wrDone), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(wrPulseEn == 1'b0, "R1 idle enable", int'(wrPulseEn), 0);
    check(wrDone == 1'b0, "R1 idle done", int'(wrDone), 0);

    doPulse(1'b0, 0, 1'b0, "R2 nominal length"); settle();
    doPulse(1'b1, 0, 1'b0, "R4 code 0 shortest"); settle();
    doPulse(1'b1, 15, 1'b0, "R4 code 15 longest"); settle();
    for (int k = 0; k < 16; k++) begin
      doPulse(1'b1, k, 1'b0, "R3 stress length per code"); settle();
    end
    doPulse(1'b0, 7, 1'b1, "R5 nominal held under noise"); settle();
    doPulse(1'b1, 3, 1'b1, "R7 triggers ignored in pulse"); settle();
    // R8 back to back: trigger in the done cycle
    doPulse(1'b1, 5, 1'b0, "R8 first of chain");
    doPulse(1'b1, 1, 1'b0, "R8 chained pulse accepted");
    doPulse(1'b0, 9, 1'b0, "R8 chained nominal"); settle();
    for (int n = 0; n < 40; n++) begin
      bit m = 1'($urandom);
      int s = int'($urandom % 16);
      doPulse(m, s, 1'($urandom), "R5 random pulse");
      if ($urandom % 2) settle();
    end
    settle();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule